// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Control

This block is a synthesizable behavioural model of the control logic found inside a byte-wide one-time-programmable memory. It takes the active-low chip select, output enable and program strobe, along with two digital flags that stand for the high-voltage conditions: the programming supply being present, and the identifier-select pin being raised above the normal logic level. From these inputs it decides which operating mode the device is in. The cell array is small, and its depth is set by a parameter.

The array comes out of reset in the blank state of all ones. A program operation can only clear bits. On the clock edge it stores the old byte ANDed with the input byte. In the read and verify modes the output drives the addressed byte and raises its tristate enable. In every other mode the output enable stays low.

When the identifier flag is set, a read returns one of two fixed identifier bytes instead of array data. Address bit 0 chooses which of the two is returned. Both codes carry odd parity in bit 7. Programming equipment uses this path to tell which part it is handling.

Top module: `otp_ctl_core`

## Requirements
- R1: When chip_sel_n is 1 and vprog_hi is 0, the block is in standby: dout_oe is 0 for every combination of out_en_n, prog_n and idsel_hi.
- R2: When chip_sel_n=0, out_en_n=0, vprog_hi=0 and idsel_hi=0, dout_oe is 1 and dout equals the stored byte at addr.
- R3: When chip_sel_n=0, out_en_n=1 and vprog_hi=0, dout_oe is 0 and the array does not change.
- R4: When vprog_hi=1, chip_sel_n=0, out_en_n=1 and prog_n=0, the byte at addr becomes (old byte AND din) on the rising clock edge, and dout_oe is 0 while this happens.
- R5: When vprog_hi=1, chip_sel_n=0, out_en_n=0 and prog_n=1, dout_oe is 1 and dout equals the stored byte at addr (program verify).
- R6: When vprog_hi=1 and chip_sel_n=1, programming is inhibited: no byte changes, even with prog_n=0, and dout_oe is 0.
- R7: When idsel_hi=1, vprog_hi=0, chip_sel_n=0, out_en_n=0 and addr[AW-1:1] is all zero, dout is D5h when addr[0]=0 and 0Eh when addr[0]=1.
- R8: In the identifier mode of R7, if any of addr[AW-1:1] is nonzero, dout is FFh.
- R9: An identifier byte on dout always has an odd number of one bits, with bit 7 as the parity bit.
- R10: After reset every array byte reads FFh.
- R11: A stored bit never goes from 0 to 1 while the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; returns the array to all ones |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| vprog_hi | input | 1 | Programming supply present |
| idsel_hi | input | 1 | Identifier-select high voltage present |
| addr | input | AW | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Output byte, 00h when not driven |
| dout_oe | output | 1 | Tristate enable for dout |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. In standby and during a program pulse the output stays off. Any identifier byte on the output has odd parity. A byte read twice at the same address never gains a one bit. Other behaviour can only be shown by the bench's scenarios. These include the exact AND-accumulation of repeated programming over every address, and the blank state after reset. They also include the two identifier codes, the all-ones answer when other address lines are high, and the fact that an inhibited or disabled strobe leaves the array untouched.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_READ    = 3'd1,
    MD_OUT_OFF = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_VERIFY  = 3'd4,
    MD_INHIBIT = 3'd5,
    MD_IDENT   = 3'd6
  } otp_mode_e;

  localparam logic [7:0] MFR_CODE = 8'hD5;
  localparam logic [7:0] DEV_CODE = 8'h0E;
  localparam logic [7:0] BLANK    = 8'hFF;

  // Mode decode: selection first, then programming supply, then identifier.
  function automatic otp_mode_e decode_mode(
    input logic cs_n, input logic oe_n, input logic pg_n,
    input logic vpp, input logic idhv);
    otp_mode_e m;
    if (cs_n)                m = vpp ? MD_INHIBIT : MD_STANDBY;
    else if (vpp) begin
      if (oe_n && !pg_n)     m = MD_PROGRAM;
      else if (!oe_n && pg_n) m = MD_VERIFY;
      else                   m = MD_OUT_OFF;
    end
    else if (!oe_n)          m = idhv ? MD_IDENT : MD_READ;
    else                     m = MD_OUT_OFF;
    return m;
  endfunction

  // Stored value after one program pulse: bits can only be cleared.
  function automatic logic [7:0] burn(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Identifier lookup; other address lines must be low.
  function automatic logic [7:0] id_lookup(input logic sel_dev, input logic upper_clear);
    if (!upper_clear) return BLANK;
    return sel_dev ? DEV_CODE : MFR_CODE;
  endfunction

  function automatic logic odd_weight(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chip_sel_n,
  input  logic      out_en_n,
  input  logic      prog_n,
  input  logic      vprog_hi,
  input  logic      idsel_hi,
  output otp_mode_e mode,
  output logic      wr_en,
  output logic      drive_arr,
  output logic      drive_id
);

  always_comb begin
    mode      = decode_mode(chip_sel_n, out_en_n, prog_n, vprog_hi, idsel_hi);
    wr_en     = (mode == MD_PROGRAM);
    drive_arr = (mode == MD_READ) || (mode == MD_VERIFY);
    drive_id  = (mode == MD_IDENT);
  end

  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel_n |-> !(wr_en || drive_arr || drive_id));

  a_r6_inhibit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n && vprog_hi) |-> (!wr_en && mode == MD_INHIBIT));

  a_r4_write_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(drive_arr || drive_id));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    rd_byte
);

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cells[g] <= BLANK;
      else if (hit) cells[g] <= burn(cells[g], din);
    end
  end

  assign rd_byte = (int'(addr) < DEPTH) ? cells[addr] : BLANK;

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
  import otp_pkg::*;
#(
  parameter int AW = 6
)(
  input  logic [AW-1:0] addr,
  output logic [7:0]    id_byte,
  output logic          id_valid
);

  logic upper_clear;

  if (AW > 1) begin : g_upper
    assign upper_clear = (addr[AW-1:1] == '0);
  end else begin : g_single
    assign upper_clear = 1'b1;
  end

  assign id_byte  = id_lookup(addr[0], upper_clear);
  assign id_valid = upper_clear;

endmodule

// File: rtl/otp_ctl_core.sv
module otp_ctl_core
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          prog_n,
  input  logic          vprog_hi,
  input  logic          idsel_hi,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe
);

  otp_mode_e  mode;
  logic       wr_en, drive_arr, drive_id, id_valid;
  logic [7:0] arr_byte, id_byte;

  otp_mode_dec u_dec (
    .clk(clk), .rst_n(rst_n),
    .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .prog_n(prog_n),
    .vprog_hi(vprog_hi), .idsel_hi(idsel_hi),
    .mode(mode), .wr_en(wr_en), .drive_arr(drive_arr), .drive_id(drive_id)
  );

  otp_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .din(din),
    .rd_byte(arr_byte)
  );

  otp_id_rom #(.AW(AW)) u_id (
    .addr(addr), .id_byte(id_byte), .id_valid(id_valid)
  );

  always_comb begin
    dout_oe = drive_arr || drive_id;
    if (drive_id)       dout = id_byte;
    else if (drive_arr) dout = arr_byte;
    else                dout = 8'h00;
  end

  a_r1_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n && !vprog_hi) |-> !dout_oe);

  a_r4_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && vprog_hi && out_en_n && !prog_n) |-> !dout_oe);

  a_r9_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_id && id_valid) |-> odd_weight(dout));

  a_r11_bits_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_arr && $past(drive_arr) && $past(rst_n) && $stable(addr))
      |-> ((dout & ~$past(dout)) == 8'h00));

endmodule

// File: tb/otp_ctl_core_tb.sv
module otp_ctl_core_tb;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_sel_n = 1'b1, out_en_n = 1'b1, prog_n = 1'b1, vprog_hi = 1'b0, idsel_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00, dout;
  logic dout_oe;
  int total = 0, bad = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  otp_ctl_core #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .prog_n(prog_n), .vprog_hi(vprog_hi), .idsel_hi(idsel_hi),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [7:0] pat_a(input int a); return 8'((a * 37 + 11) % 256); endfunction
  function automatic logic [7:0] pat_b(input int a); return 8'(~(a * 5 + 3)); endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic cs, input logic oe, input logic pg,
                        input logic vp, input logic id, input int a, input logic [7:0] d);
    chip_sel_n = cs; out_en_n = oe; prog_n = pg; vprog_hi = vp; idsel_hi = id;
    addr = AW'(a); din = d;
  endtask

  // read at normal supply, after the array settled
  task automatic read_chk(input string req, input int a);
    @(negedge clk);
    set_in(0, 0, 1, 0, 0, a, 8'h00);
    #1 chk(req, {dout_oe, dout}, {1'b1, model[a]});
  endtask

  task automatic prog_pulse(input int a, input logic [7:0] d);
    @(negedge clk);
    set_in(0, 1, 0, 1, 0, a, d);
    #1 chk("R4 off during pulse", {dout_oe, 8'h00}, 9'h000);
    model[a] = model[a] & d;
    @(negedge clk);
    set_in(0, 1, 1, 1, 0, a, d);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: blank array
    for (int a = 0; a < DEPTH; a++) read_chk("R10 blank", a);

    // R4 + R2: first pattern over all addresses
    for (int a = 0; a < DEPTH; a++) prog_pulse(a, pat_a(a));
    for (int a = 0; a < DEPTH; a++) read_chk("R2 read after prog", a);

    // R11 / R4: second pattern accumulates by AND
    for (int a = 0; a < DEPTH; a++) prog_pulse(a, pat_b(a));
    for (int a = 0; a < DEPTH; a++) read_chk("R11 and-accum", a);
    // R11: programming ones never sets bits
    prog_pulse(7, 8'hFF);
    read_chk("R11 no set", 7);

    // R5: verify mode
    for (int a = 0; a < DEPTH; a += 5) begin
      @(negedge clk);
      set_in(0, 0, 1, 1, 0, a, 8'h00);
      #1 chk("R5 verify", {dout_oe, dout}, {1'b1, model[a]});
    end

    // R1 / R6: deselected sweep over every other input combination, strobing
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      set_in(1, c[0], c[1], c[2], c[3], 9, 8'h00);
      #1 chk(c[2] ? "R6 inhibit off" : "R1 standby off", {dout_oe, 8'h00}, 9'h000);
      @(negedge clk);
    end
    read_chk("R6 inhibit kept byte", 9);

    // R3: output disabled, strobe at normal supply
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      set_in(0, 1, c[0], 0, c[1], 12, 8'h00);
      #1 chk("R3 out off", {dout_oe, 8'h00}, 9'h000);
      @(negedge clk);
    end
    read_chk("R3 byte unchanged", 12);

    // R7 / R9: identifier codes
    @(negedge clk);
    set_in(0, 0, 1, 0, 1, 0, 8'h00);
    #1 chk("R7 mfr code", {dout_oe, dout}, 9'h1D5);
    chk("R9 mfr parity", {8'h00, ^dout}, 9'h001);
    @(negedge clk);
    set_in(0, 0, 1, 0, 1, 1, 8'h00);
    #1 chk("R7 dev code", {dout_oe, dout}, 9'h10E);
    chk("R9 dev parity", {8'h00, ^dout}, 9'h001);

    // R8: other address lines high
    for (int a = 2; a < DEPTH; a++) begin
      @(negedge clk);
      set_in(0, 0, 1, 0, 1, a, 8'h00);
      #1 chk("R8 upper lines set", {dout_oe, dout}, 9'h1FF);
    end

    // R10: reset restores blank state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    read_chk("R10 blank after reset", 0);
    read_chk("R10 blank after reset", DEPTH - 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule